// File: doc/BRIEF.md
# Desaturation Fault Qualifier

This block sits between a digitized desaturation comparator and the fault-handling logic of a power-switch gate driver. It checks the comparator output against the PWM on-command so that only a sustained over-voltage during real conduction produces a trip. Turn-on transients and short noise spikes are rejected.

Each on-period starts with a programmable blanking window. During this window the comparator is ignored and the sense node is held in discharge. The block then moves to a monitoring phase. In that phase a trip needs the synchronized comparator to stay high for a programmable number of consecutive clocks. A trip produces a single-clock pulse. The block then stays quiet until the PWM command drops and a new on-period begins.

While the switch is commanded off, the sense node is held in discharge. This way every cycle starts from a known node state.

Top module: `desat_qualifier`

## Requirements
- R1: `monitorActive` is high only during an on-period whose blanking has finished and that has not tripped. One clock after `pwmOn` is sampled low, it is low.
- R2: For `blankCount` = N ≥ 1, `monitorActive` rises N+1 clocks after the first clock edge that samples `pwmOn` high. During those clocks the comparator has no effect.
- R3: `nodeReset` is high while the switch is off and during blanking. It is low while monitoring and after a trip. `nodeReset` and `monitorActive` are never high together.
- R4: While monitoring, a trip occurs once the synchronized comparator has been high on G consecutive monitoring clocks, where G is `glitchCount`. A `glitchCount` of 0 acts as 1.
- R5: A low comparator sample during monitoring restarts the consecutive count from zero, so bursts shorter than G clocks never trip.
- R6: `pwmOn` sampled low in any phase returns the block to the off/reset phase. A later rising command starts a fresh blanking window.
- R7: `cmpRaw` passes through a two-flop synchronizer. A level sampled at one edge first takes part in counting two edges later.
- R8: `tripPulse` is high for exactly one clock per trip. At most one trip is issued per on-period.
- R9: With `blankCount` = 0, `monitorActive` is high after the first clock edge that samples `pwmOn` high.
- R10: While `rstN` is low, `nodeReset` = 1, `monitorActive` = 0 and `tripPulse` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmOn | input | 1 | Gate on-command, synchronous to clk |
| cmpRaw | input | 1 | Raw desaturation comparator output (asynchronous) |
| blankCount | input | CNT_W | Blanking length in clocks |
| glitchCount | input | CNT_W | Consecutive high clocks required to trip (0 acts as 1) |
| nodeReset | output | 1 | Sense-node discharge enable |
| monitorActive | output | 1 | Comparator decision window open |
| tripPulse | output | 1 | One-clock fault trip |

## Verification
A phase register stuck in or skipping blanking shows up within one clock as a wrong `nodeReset`/`monitorActive` pair. A deglitch counter that fails to clear, or that counts during blanking, shows up as a `tripPulse` several clocks early or late, or as a missing or extra pulse. A wrong synchronizer depth shifts every trip by a whole clock. Because all three outputs are compared each clock against an independent timing model, such a fault is reported at the first edge where it takes effect.

// File: rtl/desat_pkg.sv
package desat_pkg;

  typedef enum logic [1:0] {
    PH_RESET   = 2'd0,
    PH_BLANK   = 2'd1,
    PH_MONITOR = 2'd2,
    PH_TRIPPED = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic blankRun;   // advance blanking counter, else clear
    logic glitchRun;  // count comparator highs, else clear
  } strobe_t;

endpackage

// File: rtl/desat_datapath.sv
module desat_datapath
  import desat_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpRaw,
  input  logic [CNT_W-1:0] blankCount,
  input  logic [CNT_W-1:0] glitchCount,
  input  strobe_t          strobe,
  output logic             blankZero,
  output logic             blankDone,
  output logic             glitchDone
);

  localparam int WIDE_W = CNT_W + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   cmpSync;
  logic [CNT_W-1:0]       blankCnt;
  logic [CNT_W-1:0]       glitchCnt;
  logic [WIDE_W-1:0]      glitchNeed;

  // Synchronizer chain; stages set by parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], cmpRaw};
  end
  assign cmpSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                blankCnt <= '0;
    else if (strobe.blankRun) blankCnt <= blankCnt + 1'b1;
    else                      blankCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             glitchCnt <= '0;
    else if (strobe.glitchRun && cmpSync)  glitchCnt <= glitchCnt + 1'b1;
    else                                   glitchCnt <= '0;
  end

  assign glitchNeed = (glitchCount == '0) ? WIDE_W'(1) : {1'b0, glitchCount};
  assign blankZero  = (blankCount == '0);
  assign blankDone  = ({1'b0, blankCnt} + WIDE_W'(1)) >= {1'b0, blankCount};
  assign glitchDone = cmpSync && (({1'b0, glitchCnt} + WIDE_W'(1)) >= glitchNeed);

endmodule

// File: rtl/desat_control.sv
module desat_control
  import desat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwmOn,
  input  logic    blankZero,
  input  logic    blankDone,
  input  logic    glitchDone,
  output strobe_t strobe,
  output logic    nodeReset,
  output logic    monitorActive,
  output logic    tripPulse
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (!pwmOn) begin
      phaseNext = PH_RESET;
    end else begin
      unique case (phase)
        PH_RESET:   phaseNext = blankZero ? PH_MONITOR : PH_BLANK;
        PH_BLANK:   phaseNext = blankDone ? PH_MONITOR : PH_BLANK;
        PH_MONITOR: phaseNext = glitchDone ? PH_TRIPPED : PH_MONITOR;
        PH_TRIPPED: phaseNext = PH_TRIPPED;
        default:    phaseNext = PH_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_RESET;
      tripPulse <= 1'b0;
    end else begin
      phase     <= phaseNext;
      tripPulse <= pwmOn && (phase == PH_MONITOR) && glitchDone;
    end
  end

  assign strobe.blankRun  = (phase == PH_BLANK);
  assign strobe.glitchRun = (phase == PH_MONITOR);
  assign nodeReset        = (phase == PH_RESET) || (phase == PH_BLANK);
  assign monitorActive    = (phase == PH_MONITOR);

endmodule

// File: rtl/desat_qualifier.sv
module desat_qualifier
  import desat_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmOn,
  input  logic             cmpRaw,
  input  logic [CNT_W-1:0] blankCount,
  input  logic [CNT_W-1:0] glitchCount,
  output logic             nodeReset,
  output logic             monitorActive,
  output logic             tripPulse
);

  strobe_t strobe;
  logic    blankZero, blankDone, glitchDone;

  desat_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmpRaw     (cmpRaw),
    .blankCount (blankCount),
    .glitchCount(glitchCount),
    .strobe     (strobe),
    .blankZero  (blankZero),
    .blankDone  (blankDone),
    .glitchDone (glitchDone)
  );

  desat_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .pwmOn        (pwmOn),
    .blankZero    (blankZero),
    .blankDone    (blankDone),
    .glitchDone   (glitchDone),
    .strobe       (strobe),
    .nodeReset    (nodeReset),
    .monitorActive(monitorActive),
    .tripPulse    (tripPulse)
  );

endmodule

// File: rtl/desat_qualifier_chk.sv
module desat_qualifier_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmOn,
  input logic             cmpRaw,
  input logic [CNT_W-1:0] blankCount,
  input logic [CNT_W-1:0] glitchCount,
  input logic             nodeReset,
  input logic             monitorActive,
  input logic             tripPulse
);

  AST_OFF_NO_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> !monitorActive); // R1

  AST_OFF_NODE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> nodeReset); // R6

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(nodeReset && monitorActive)); // R3

  AST_TRIP_AFTER_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripPulse) |-> $past(monitorActive)); // R4

  AST_TRIP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |=> !tripPulse); // R8

  AST_ZERO_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOn && nodeReset && blankCount == '0) |=> monitorActive); // R9

endmodule

bind desat_qualifier desat_qualifier_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/desat_qualifier_tb_top.sv
module desat_qualifier_tb_top;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmOn = 1'b0;
  logic cmpRaw = 1'b0;
  logic [CNT_W-1:0] blankCount = '0;
  logic [CNT_W-1:0] glitchCount = '0;
  logic nodeReset, monitorActive, tripPulse;

  always #2.5 clk = ~clk;  // 200 MHz

  desat_qualifier #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .pwmOn(pwmOn), .cmpRaw(cmpRaw),
    .blankCount(blankCount), .glitchCount(glitchCount),
    .nodeReset(nodeReset), .monitorActive(monitorActive), .tripPulse(tripPulse)
  );

  int errors = 0;
  int checks = 0;
  int trips = 0;
  bit finished = 1'b0;
  string curTag = "R10";

  // Behavioural timing model
  int onCycles = 0;
  int highRun = 0;
  bit tripped = 1'b0;
  bit s1 = 1'b0, s2 = 1'b0;
  bit expReset = 1'b1, expMon = 1'b0, expTrip = 1'b0;

  always @(posedge clk) begin
    int need;
    bit wasMon;
    if (!rstN) begin
      onCycles = 0; highRun = 0; tripped = 0; s1 = 0; s2 = 0;
      expReset = 1; expMon = 0; expTrip = 0;
    end else begin
      need = (glitchCount == 0) ? 1 : int'(glitchCount);
      expTrip = 0;
      if (!pwmOn) begin
        onCycles = 0; highRun = 0; tripped = 0;
      end else begin
        wasMon = (onCycles > int'(blankCount)) && !tripped;
        if (wasMon) begin
          if (s2) begin
            highRun++;
            if (highRun >= need) begin tripped = 1; expTrip = 1; end
          end else highRun = 0;
        end
        onCycles++;
      end
      expReset = !pwmOn || (!tripped && onCycles <= int'(blankCount));
      expMon   = pwmOn && !tripped && onCycles > int'(blankCount);
      s2 = s1; s1 = cmpRaw;
    end
  end

  task automatic check(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", curTag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check("nodeReset (R3)", nodeReset, expReset);
      check("monitorActive (R1)", monitorActive, expMon);
      check("tripPulse (R4)", tripPulse, expTrip);
      if (tripPulse === 1'b1) trips++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int t0;
    // R10 reset state
    tick(3);
    check("reset nodeReset R10", nodeReset, 1'b1);
    check("reset monitorActive R10", monitorActive, 1'b0);
    check("reset tripPulse R10", tripPulse, 1'b0);
    rstN = 1'b1;
    tick(3);

    // R9 zero blanking
    curTag = "R9";
    blankCount = 0; glitchCount = 3;
    pwmOn = 1; tick(1);
    check("zero blank monitor R9", monitorActive, 1'b1);
    tick(10); pwmOn = 0; tick(4);

    // R2 blanking masks comparator; R7 sync latency
    curTag = "R2";
    blankCount = 6; glitchCount = 2; cmpRaw = 1;
    pwmOn = 1; tick(6);
    check("still blanking R2", monitorActive, 1'b0);
    check("node held R2", nodeReset, 1'b1);
    tick(1);
    check("monitor open R2", monitorActive, 1'b1);
    tick(5); pwmOn = 0; cmpRaw = 0; tick(4);

    // R5 bursts shorter than deglitch
    curTag = "R5";
    blankCount = 3; glitchCount = 5; t0 = trips;
    pwmOn = 1; tick(5);
    for (int i = 0; i < 8; i++) begin
      cmpRaw = 1; tick(4);
      cmpRaw = 0; tick(1);
    end
    check("no trip on short bursts R5", (trips == t0), 1'b1);
    pwmOn = 0; tick(4);

    // R4 zero deglitch acts as one; R7 single-clock comparator pulse
    curTag = "R7";
    blankCount = 2; glitchCount = 0; t0 = trips;
    pwmOn = 1; tick(6);
    cmpRaw = 1; tick(1); cmpRaw = 0; tick(5);
    check("one-clock pulse trips R7", (trips == t0 + 1), 1'b1);
    pwmOn = 0; tick(4);

    curTag = "R4";
    blankCount = 1; glitchCount = 4; t0 = trips;
    pwmOn = 1; tick(4);
    cmpRaw = 1; tick(3); cmpRaw = 0; tick(2);
    cmpRaw = 1; tick(8); cmpRaw = 0;
    check("sustained high trips R4", (trips == t0 + 1), 1'b1);
    pwmOn = 0; tick(4);

    // R6 abort in blanking and in monitoring
    curTag = "R6";
    blankCount = 8; glitchCount = 2; cmpRaw = 1;
    pwmOn = 1; tick(4); pwmOn = 0; tick(1);
    check("abort blank R6", nodeReset, 1'b1);
    pwmOn = 1; tick(10); pwmOn = 0; cmpRaw = 0; tick(1);
    check("abort monitor R6", monitorActive, 1'b0);
    pwmOn = 1; tick(3); pwmOn = 0; tick(3);

    // R8 one trip per on-period under persistent fault
    curTag = "R8";
    blankCount = 2; glitchCount = 3; cmpRaw = 1; t0 = trips;
    pwmOn = 1; tick(40);
    check("single trip per period R8", (trips == t0 + 1), 1'b1);
    check("tripped node released R3", nodeReset, 1'b0);
    pwmOn = 0; tick(2); pwmOn = 1; tick(20);
    check("retrip after new turn-on R8", (trips == t0 + 2), 1'b1);
    pwmOn = 0; cmpRaw = 0; tick(4);

    // R1/R3 normal switching with no fault
    curTag = "R1";
    blankCount = 4; glitchCount = 2; t0 = trips;
    for (int k = 0; k < 6; k++) begin
      pwmOn = 1; tick(12 + k);
      pwmOn = 0; tick(5);
    end
    check("no trip in clean switching R1", (trips == t0), 1'b1);
    curTag = "R3";
    tick(2);
    summary();
  end

endmodule